// File: doc/BRIEF.md
# Processor Status Word and Exception Screen

This block keeps the 16-bit processor status word of a small 16-bit RISC core: the privilege mode, a three-bit priority level and the three mutually exclusive sign flags. The core's write-back stage asks it to update the flags from each result it writes to a register. The interrupt entry and return sequencer uses a separate context port to load the mode, the priority and the flags in one write. That port takes precedence over a flag update requested in the same cycle.

Every fetched instruction is screened as it is presented. There are two checks: the reserved opcode, and the return-from-interrupt opcode issued outside supervisor mode. Each check that fires gives a one-cycle exception pulse on the following clock. The block also keeps the stack pointer of the mode that is not running in one of two shadow registers. When a context write changes the mode, the block saves the live stack register R6 and gives back the value R6 must be reloaded with in that same cycle.

Top module: `psr_guard`

## Requirements
- R1: After reset the status word reads 0x0002: supervisor mode (bit 15 = 0), priority 0, Z set and N, P clear. Both exception outputs and the reload strobe are low, and the user stack is not selected.
- R2: A flag update (`cc_we_i`) with no context write sets the flags on the next clock from `cc_result_i` read as a two's complement number. N (bit 2) is set when it is negative, Z (bit 1) when it is zero, and P (bit 0) when it is positive. Exactly one flag is ever set.
- R3: A context write loads bit 15 (mode, 0 = supervisor, 1 = user), bits 10:8 (priority, 7 highest, 0 lowest) and bits 2:0 (flags) from `ctx_word_i` on the next clock. All other status bits always read as 0, whatever is written to them.
- R4: When a context write and a flag update occur in the same cycle, the flags come from the context word.
- R5: A valid instruction whose bits 15:12 are 1101 raises `exc_illegal_o` for exactly one cycle, on the clock after it is presented. Without `instr_valid_i` there is no pulse.
- R6: A valid instruction with opcode 1000 (return from interrupt) raises `exc_priv_o` for one cycle on the next clock, but only when the mode in effect when it is presented is user. In supervisor mode it raises nothing.
- R7: The two exception outputs are never high together, and the illegal-opcode check takes precedence.
- R8: `use_usp_o` and `user_mode_o` equal status bit 15, so R6 addresses the user stack pointer in user mode and the supervisor stack pointer otherwise.
- R9: A context write that switches from user to supervisor asserts `sp_load_en_o` in that cycle, with `sp_load_o` holding the saved supervisor pointer (0x3000 after reset). It also saves `sp_cur_i` as the user pointer.
- R10: A context write that switches from supervisor to user asserts `sp_load_en_o` with the saved user pointer (0x0000 after reset) and saves `sp_cur_i` as the supervisor pointer. A context write that keeps the mode does not assert `sp_load_en_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 16 | Fetched instruction word |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| cc_we_i | input | 1 | Request a flag update from a result |
| cc_result_i | input | 16 | Result value that sets the flags |
| ctx_we_i | input | 1 | Context write (interrupt entry or return) |
| ctx_word_i | input | 16 | Status word to load on a context write |
| sp_cur_i | input | 16 | Present value of R6 |
| psr_o | output | 16 | Status word |
| user_mode_o | output | 1 | 1 in user mode |
| prio_o | output | 3 | Priority level |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_p_o | output | 1 | Positive flag |
| use_usp_o | output | 1 | R6 is the user stack pointer |
| exc_illegal_o | output | 1 | Reserved-opcode exception pulse |
| exc_priv_o | output | 1 | Privilege-mode exception pulse |
| sp_load_o | output | 16 | Value to reload R6 with on a mode switch |
| sp_load_en_o | output | 1 | Reload R6 this cycle |

## Verification
The one-hot flag property relies on every context word carrying exactly one of bits 2:0 set. This holds because the sequencer writes back a status word this block produced. The bench builds each context word from a legal flag triple and scatters arbitrary values only into the undefined bits. The exception properties expect each valid strobe to stand for a separate instruction, so they do not depend on how long a strobe is held. The bench still presents back-to-back valid cycles to confirm that each one produces its own pulse.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OPC_W  = 4;

  localparam logic [OPC_W-1:0] OPC_RESERVED = 4'b1101;
  localparam logic [OPC_W-1:0] OPC_RET_INT  = 4'b1000;

  typedef enum logic {
    MODE_SUP = 1'b0,
    MODE_USR = 1'b1
  } mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};
endpackage

// File: rtl/psr_state.sv
module psr_state
  import psr_pkg::*;
#(
  parameter int unsigned W        = WORD_W,
  parameter int unsigned MODE_POS = 15,
  parameter int unsigned PRIO_HI  = 10,
  parameter int unsigned PRIO_LO  = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cc_we_i,
  input  logic [W-1:0] cc_result_i,
  input  logic         ctx_we_i,
  input  logic [W-1:0] ctx_word_i,
  output logic [W-1:0] psr_o
);
  localparam int unsigned PRIO_W = PRIO_HI - PRIO_LO + 1;

  mode_e             mode_q;
  logic [PRIO_W-1:0] prio_q;
  flags_t            flags_q;
  flags_t            flags_res;

  // sign classification of a write-back result
  always_comb begin
    flags_res.n = cc_result_i[W-1];
    flags_res.z = (cc_result_i == '0);
    flags_res.p = ~cc_result_i[W-1] & (cc_result_i != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_SUP;
      prio_q  <= '0;
      flags_q <= FLAGS_RESET;
    end else if (ctx_we_i) begin
      mode_q  <= mode_e'(ctx_word_i[MODE_POS]);
      prio_q  <= ctx_word_i[PRIO_HI:PRIO_LO];
      flags_q <= flags_t'(ctx_word_i[2:0]);
    end else if (cc_we_i) begin
      flags_q <= flags_res;
    end
  end

  always_comb begin
    psr_o                  = '0;
    psr_o[MODE_POS]        = mode_q;
    psr_o[PRIO_HI:PRIO_LO] = prio_q;
    psr_o[2:0]             = flags_q;
  end

  logic unused_ctx_bits;
  assign unused_ctx_bits = ^ctx_word_i;

  p_flags_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(flags_q) == 1);

  p_cc_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_we_i && !ctx_we_i) |=> (flags_q.z == ($past(cc_result_i) == '0)));

  p_cc_sign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_we_i && !ctx_we_i) |=> (flags_q.n == $past(cc_result_i[W-1])));

  p_ctx_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_we_i |=> (psr_o[2:0] == $past(ctx_word_i[2:0])));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctx_we_i && !cc_we_i) |=> $stable(psr_o));
endmodule

// File: rtl/instr_screen.sv
module instr_screen
  import psr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opc_i,
  input  logic             valid_i,
  input  logic             user_mode_i,
  output logic             exc_illegal_o,
  output logic             exc_priv_o
);
  logic hit_illegal;
  logic hit_priv;

  // reserved opcode outranks the privilege check
  assign hit_illegal = valid_i && (opc_i == OPC_RESERVED);
  assign hit_priv    = valid_i && (opc_i == OPC_RET_INT) && user_mode_i && !hit_illegal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_illegal_o <= 1'b0;
      exc_priv_o    <= 1'b0;
    end else begin
      exc_illegal_o <= hit_illegal;
      exc_priv_o    <= hit_priv;
    end
  end

  p_illegal_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opc_i == OPC_RESERVED) |=> exc_illegal_o);

  p_illegal_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !exc_illegal_o);

  p_priv_user_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opc_i == OPC_RET_INT && user_mode_i) |=> exc_priv_o);

  p_priv_sup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !user_mode_i |=> !exc_priv_o);

  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_illegal_o && exc_priv_o));
endmodule

// File: rtl/sp_shadow.sv
module sp_shadow
  import psr_pkg::*;
#(
  parameter int unsigned    W        = WORD_W,
  parameter logic [W-1:0]   SSP_INIT = 16'h3000,
  parameter logic [W-1:0]   USP_INIT = 16'h0000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctx_we_i,
  input  logic         cur_user_i,
  input  logic         new_user_i,
  input  logic [W-1:0] sp_cur_i,
  output logic [W-1:0] sp_load_o,
  output logic         sp_load_en_o
);
  logic [W-1:0] ssp_q;
  logic [W-1:0] usp_q;
  logic         swap;

  assign swap         = ctx_we_i && (cur_user_i != new_user_i);
  assign sp_load_en_o = swap;
  // the pointer of the mode being entered
  assign sp_load_o    = cur_user_i ? ssp_q : usp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ssp_q <= SSP_INIT;
      usp_q <= USP_INIT;
    end else if (swap) begin
      if (cur_user_i) usp_q <= sp_cur_i;
      else            ssp_q <= sp_cur_i;
    end
  end

  p_entry_save_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap && cur_user_i) |=> (usp_q == $past(sp_cur_i)));

  p_return_save_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap && !cur_user_i) |=> (ssp_q == $past(sp_cur_i)));

  p_no_swap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_we_i && cur_user_i == new_user_i) |-> !sp_load_en_o);
endmodule

// File: rtl/psr_guard.sv
module psr_guard
  import psr_pkg::*;
#(
  parameter int unsigned  W        = WORD_W,
  parameter int unsigned  MODE_POS = 15,
  parameter int unsigned  PRIO_HI  = 10,
  parameter int unsigned  PRIO_LO  = 8,
  parameter logic [W-1:0] SSP_INIT = 16'h3000,
  parameter logic [W-1:0] USP_INIT = 16'h0000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [15:0]  instr_i,
  input  logic         instr_valid_i,
  input  logic         cc_we_i,
  input  logic [15:0]  cc_result_i,
  input  logic         ctx_we_i,
  input  logic [15:0]  ctx_word_i,
  input  logic [15:0]  sp_cur_i,
  output logic [15:0]  psr_o,
  output logic         user_mode_o,
  output logic [2:0]   prio_o,
  output logic         flag_n_o,
  output logic         flag_z_o,
  output logic         flag_p_o,
  output logic         use_usp_o,
  output logic         exc_illegal_o,
  output logic         exc_priv_o,
  output logic [15:0]  sp_load_o,
  output logic         sp_load_en_o
);
  logic [W-1:0] psr;

  psr_state #(
    .W(W), .MODE_POS(MODE_POS), .PRIO_HI(PRIO_HI), .PRIO_LO(PRIO_LO)
  ) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cc_we_i     (cc_we_i),
    .cc_result_i (cc_result_i),
    .ctx_we_i    (ctx_we_i),
    .ctx_word_i  (ctx_word_i),
    .psr_o       (psr)
  );

  instr_screen u_screen (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .opc_i         (instr_i[15:12]),
    .valid_i       (instr_valid_i),
    .user_mode_i   (psr[MODE_POS]),
    .exc_illegal_o (exc_illegal_o),
    .exc_priv_o    (exc_priv_o)
  );

  sp_shadow #(
    .W(W), .SSP_INIT(SSP_INIT), .USP_INIT(USP_INIT)
  ) u_sp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctx_we_i     (ctx_we_i),
    .cur_user_i   (psr[MODE_POS]),
    .new_user_i   (ctx_word_i[MODE_POS]),
    .sp_cur_i     (sp_cur_i),
    .sp_load_o    (sp_load_o),
    .sp_load_en_o (sp_load_en_o)
  );

  assign psr_o       = psr;
  assign user_mode_o = psr[MODE_POS];
  assign use_usp_o   = psr[MODE_POS];
  assign prio_o      = psr[PRIO_HI:PRIO_LO];
  assign flag_n_o    = psr[2];
  assign flag_z_o    = psr[1];
  assign flag_p_o    = psr[0];

  logic unused_instr;
  assign unused_instr = ^instr_i[11:0];

  p_stack_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_we_i && ctx_word_i[MODE_POS]) |=> use_usp_o);

  p_stack_sup_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_we_i && !ctx_word_i[MODE_POS]) |=> !use_usp_o);
endmodule

// File: tb/tb_psr_guard.sv
module tb_psr_guard;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i = '0;
  logic        instr_valid_i = 1'b0;
  logic        cc_we_i = 1'b0;
  logic [15:0] cc_result_i = '0;
  logic        ctx_we_i = 1'b0;
  logic [15:0] ctx_word_i = '0;
  logic [15:0] sp_cur_i = '0;
  logic [15:0] psr_o;
  logic        user_mode_o;
  logic [2:0]  prio_o;
  logic        flag_n_o, flag_z_o, flag_p_o;
  logic        use_usp_o;
  logic        exc_illegal_o, exc_priv_o;
  logic [15:0] sp_load_o;
  logic        sp_load_en_o;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [15:0] m_psr = 16'h0002;
  logic [15:0] m_ssp = 16'h3000;
  logic [15:0] m_usp = 16'h0000;
  logic        m_ill = 1'b0;
  logic        m_priv = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  psr_guard dut (.*);

  function automatic logic [2:0] classify(logic [15:0] v);
    if (v[15])      return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic step(string tag, logic v, logic [15:0] ins, logic ccw, logic [15:0] ccr,
                      logic cw, logic [15:0] cword, logic [15:0] sp);
    logic [44:0] got, exp;
    logic        e_en;
    @(negedge clk_i);
    instr_valid_i = v;  instr_i = ins;
    cc_we_i = ccw;      cc_result_i = ccr;
    ctx_we_i = cw;      ctx_word_i = cword;
    sp_cur_i = sp;
    #1;
    e_en = cw && (cword[15] != m_psr[15]);
    exp = {m_psr, m_psr[15], m_psr[10:8], m_psr[2:0], m_psr[15], m_ill, m_priv, e_en,
           e_en ? (m_psr[15] ? m_ssp : m_usp) : 16'h0};
    got = {psr_o, user_mode_o, prio_o, flag_n_o, flag_z_o, flag_p_o, use_usp_o,
           exc_illegal_o, exc_priv_o, sp_load_en_o, sp_load_en_o ? sp_load_o : 16'h0};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
    @(posedge clk_i);
    m_ill  = v && (ins[15:12] == 4'b1101);
    m_priv = v && (ins[15:12] == 4'b1000) && m_psr[15];
    if (cw) begin
      if (cword[15] != m_psr[15]) begin
        if (m_psr[15]) m_usp = sp;
        else           m_ssp = sp;
      end
      m_psr = cword & 16'h8707;
    end else if (ccw) begin
      m_psr[2:0] = classify(ccr);
    end
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    idle("R1 reset state");
    // R2 flag classification
    step("R2 negative", 1'b0, 16'h0, 1'b1, 16'h8000, 1'b0, 16'h0, 16'h0);
    step("R2 zero",     1'b0, 16'h0, 1'b1, 16'h0000, 1'b0, 16'h0, 16'h0);
    step("R2 positive", 1'b0, 16'h0, 1'b1, 16'h0005, 1'b0, 16'h0, 16'h0);
    step("R2 minus one",1'b0, 16'h0, 1'b1, 16'hFFFF, 1'b0, 16'h0, 16'h0);
    step("R2 max pos",  1'b0, 16'h0, 1'b1, 16'h7FFF, 1'b0, 16'h0, 16'h0);
    // R3 context write with junk in undefined bits, mode kept
    step("R3 ctx junk", 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h7FFC, 16'h1111);
    // R4 ctx and cc together
    step("R4 ctx wins", 1'b0, 16'h0, 1'b1, 16'h0000, 1'b1, 16'h0201, 16'h1111);
    idle("R4 observe");
    // R5 illegal opcode
    step("R5 illegal",     1'b1, 16'hD000, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0);
    step("R5 not valid",   1'b0, 16'hD123, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0);
    step("R5 back2back a", 1'b1, 16'hDFFF, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0);
    step("R5 back2back b", 1'b1, 16'hD001, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0);
    step("R6 ret in sup",  1'b1, 16'h8000, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0);
    step("R6 sup quiet",   1'b1, 16'h1234, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0);
    // R10 supervisor to user
    step("R10 to user", 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h8302, 16'h4000);
    step("R8 user stack", 1'b1, 16'h8000, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0);
    step("R6 ret in user", 1'b1, 16'hD123, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0);
    step("R7 illegal only", 1'b1, 16'h8FFF, 1'b1, 16'h0000, 1'b0, 16'h0, 16'h0);
    step("R6 priv again", 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0);
    // R9 user to supervisor, ret presented in same cycle uses old mode
    step("R9 entry", 1'b1, 16'h8000, 1'b0, 16'h0, 1'b1, 16'h0704, 16'hFE00);
    step("R6 old mode", 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0);
    step("R10 same mode", 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0001, 16'hAAAA);
    step("R10 back to user", 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'hF8FA, 16'h2222);
    step("R10 user same", 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h8504, 16'h5555);
    step("R9 entry again", 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0002, 16'h6666);
    step("R10 return again", 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h8001, 16'h7777);
    idle("R8 final");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule